// File: doc/BRIEF.md
# Branch Prediction Side Buffer for a Fetch Line Queue

This block travels next to the instruction line queue that sits between fetch and the pipeline core. Each fetched line arrives with a base address and, for every instruction slot, a slot-valid bit, a branch bit, a predicted-taken bit and a predicted target. The block stores these per-slot hints in line-wide entries kept in arrival order. It then issues the live slots one at a time, and each issued instruction carries its prediction with it into decode.

One cycle after a slot is issued, that instruction sits in decode. The core then supplies the resolved direction and target. The block compares them with the prediction it sent. On a disagreement it raises a redirect with the corrected address, which loads the fetch-side PC and the core PC in that same cycle. At the following clock edge it discards every buffered line. Non-branch instructions pass through with an empty prediction and never cause a redirect. Slots behind a predicted-taken branch in the same line are dropped when the line is written, so they are never issued.

Top module: `tgt_pred_buf`

## Requirements
- R1: After reset the buffer is empty (`buf_empty`=1, `buf_full`=0, `fill_ready`=1), `issue_valid`=0 and `redirect_valid`=0.
- R2: Lines issue in the order they were accepted, and within a line the live slots issue in ascending slot order. The issued address is the line base plus 4 times the slot index (slot 0 at the base).
- R3: Once `LINES` (default 3) lines are held, `buf_full`=1 and `fill_ready`=0. A fill offered while full is dropped and never issues.
- R4: Within a line, any slot above the lowest-numbered slot that is valid, a branch and predicted taken is never issued. Slots whose `fill_slot_vld` bit is 0 are skipped. A line with no live slot is not stored.
- R5: An issued instruction carries its predicted-taken flag and target. For a non-branch, both flag and target are 0. For a branch predicted not taken, the target is 0.
- R6: In the cycle after a branch issues, `redirect_valid`=1 if `res_taken` differs from the predicted direction. `redirect_pc` is then `res_target` when `res_taken`=1, and otherwise the branch address plus 4.
- R7: If the branch was predicted taken and resolves taken, `redirect_valid`=1 with `redirect_pc`=`res_target` exactly when `res_target` differs from the predicted target. Otherwise no redirect occurs.
- R8: An issued non-branch never produces `redirect_valid`, whatever `res_taken` and `res_target` are.
- R9: While `redirect_valid`=1, `issue_valid`=0 and any offered fill is dropped. From the next cycle the buffer is empty and no redirect is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | A fetched line is offered |
| fill_ready | output | 1 | A line slot is free |
| fill_base_pc | input | AW | Address of slot 0 of the offered line |
| fill_slot_vld | input | SLOTS | Per-slot instruction present |
| fill_is_br | input | SLOTS | Per-slot branch flag |
| fill_pred_tk | input | SLOTS | Per-slot predicted-taken flag |
| fill_pred_tgt | input | SLOTS*AW | Per-slot predicted target, slot i at bits [i*AW +: AW] |
| buf_empty | output | 1 | No line held |
| buf_full | output | 1 | All line slots held |
| issue_valid | output | 1 | An instruction is offered to decode |
| issue_ready | input | 1 | Core accepts the offered instruction |
| issue_pc | output | AW | Address of the offered instruction |
| issue_is_br | output | 1 | Offered instruction is a branch |
| issue_pred_tk | output | 1 | Predicted-taken flag sent with it |
| issue_pred_tgt | output | AW | Predicted target sent with it |
| res_taken | input | 1 | Resolved direction of the instruction in decode |
| res_target | input | AW | Resolved target of the instruction in decode |
| redirect_valid | output | 1 | Misprediction: load fetch PC and core PC now |
| redirect_pc | output | AW | Corrected address for both PCs |

## Verification
The hardest situation to reach is a fill arriving in the very cycle a redirect is raised. The fill must be dropped, and the flush must still leave the queue empty, with other lines queued behind the mispredicted branch. The stimulus gets there by queueing two lines, issuing a wrongly predicted branch, and holding `fill_valid` high with a fresh line exactly in the decode cycle where `redirect_valid` appears. Taken-target mismatches and masking behind a taken branch are reached by placing the predicted branch in a middle slot of a line and issuing up to it.

// File: rtl/tpb_pkg.sv
// Package tpb_pkg
// Shared constants and types for the prediction side buffer.
// Assumes fixed 4-byte instructions.
package tpb_pkg;
    localparam int unsigned INSN_SHIFT = 2;

    // Outcome of comparing a prediction with the resolved branch
    typedef enum logic [1:0] {
        VERD_MATCH    = 2'd0,
        VERD_DIR_MISS = 2'd1,
        VERD_TGT_MISS = 2'd2,
        VERD_NONE     = 2'd3
    } verdict_e;
endpackage

// File: rtl/tpb_fill_mask.sv
// Module tpb_fill_mask
// Computes which slots of an incoming line stay live. A slot survives
// when it is present and no lower present slot is a predicted-taken branch.
// Assumes the predicted-taken bit matters only when the branch bit is set.
module tpb_fill_mask #(
    parameter int unsigned SLOTS = 4
) (
    input  logic [SLOTS-1:0] slot_vld,
    input  logic [SLOTS-1:0] is_br,
    input  logic [SLOTS-1:0] pred_tk,
    output logic [SLOTS-1:0] live
);
    logic [SLOTS:0] taken_seen;

    assign taken_seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            // propagate the "taken branch already seen" chain
            assign taken_seen[g+1] = taken_seen[g] | (slot_vld[g] & is_br[g] & pred_tk[g]);
            // slot is live if present and not shadowed
            assign live[g] = slot_vld[g] & ~taken_seen[g];
        end
    endgenerate
endmodule

// File: rtl/tpb_first_set.sv
// Module tpb_first_set
// Priority encoder: index of the lowest set bit of a mask, and whether any is set.
// Assumes the index is don't-care when no bit is set (reported as 0).
module tpb_first_set #(
    parameter int unsigned W  = 4,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          found
);
    // scan downwards so the lowest set bit wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpb_line_store.sv
// Module tpb_line_store
// Circular queue of LINES line entries. Each entry holds a base address and
// per-slot live, branch, predicted-taken and target fields. The head slot is
// the lowest live slot of the oldest line; popping clears it, and the line
// retires once no live slot remains. Flush empties the queue in one edge.
// Assumes push is only asserted when not full and with a nonzero live mask.
module tpb_line_store #(
    parameter int unsigned LINES = 3,
    parameter int unsigned SLOTS = 4,
    parameter int unsigned AW    = 32,
    localparam int unsigned PW   = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int unsigned CW   = $clog2(LINES + 1),
    localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [AW-1:0]         push_base,
    input  logic [SLOTS-1:0]      push_live,
    input  logic [SLOTS-1:0]      push_br,
    input  logic [SLOTS-1:0]      push_tk,
    input  logic [SLOTS*AW-1:0]   push_tgt,
    input  logic                  pop,
    input  logic                  flush,
    output logic                  empty,
    output logic                  full,
    output logic [AW-1:0]         head_pc,
    output logic                  head_br,
    output logic                  head_tk,
    output logic [AW-1:0]         head_tgt
);
    import tpb_pkg::*;

    logic [SLOTS-1:0]    live_q [LINES];
    logic [SLOTS-1:0]    br_q   [LINES];
    logic [SLOTS-1:0]    tk_q   [LINES];
    logic [SLOTS*AW-1:0] tgt_q  [LINES];
    logic [AW-1:0]       base_q [LINES];
    logic [PW-1:0]       wr_ptr, rd_ptr;
    logic [CW-1:0]       count;

    logic [SW-1:0]       head_idx;
    logic                head_found;
    logic [SLOTS-1:0]    head_live;
    logic [SLOTS-1:0]    head_clr;
    logic                head_retire;

    assign empty     = (count == '0);
    assign full      = (count == CW'(LINES));
    assign head_live = live_q[rd_ptr];

    tpb_first_set #(.W(SLOTS)) u_pick (
        .mask  (head_live),
        .idx   (head_idx),
        .found (head_found)
    );

    // read out the fields of the head slot
    always_comb begin
        head_br  = 1'b0;
        head_tk  = 1'b0;
        head_tgt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (head_idx == SW'(i)) begin
                head_br  = br_q[rd_ptr][i];
                head_tk  = tk_q[rd_ptr][i];
                head_tgt = tgt_q[rd_ptr][i*AW +: AW];
            end
        end
        head_pc = base_q[rd_ptr] + (AW'(head_idx) << INSN_SHIFT);
    end

    // live mask of the head line once the popped slot is removed
    always_comb begin
        head_clr = head_live;
        for (int i = 0; i < SLOTS; i++) begin
            if (head_idx == SW'(i)) head_clr[i] = 1'b0;
        end
        head_retire = pop && head_found && (head_clr == '0);
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(LINES - 1)) ? '0 : wr_ptr + 1'b1;
            if (head_retire) rd_ptr <= (rd_ptr == PW'(LINES - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !head_retire)      count <= count + 1'b1;
            else if (!push && head_retire) count <= count - 1'b1;
        end
    end

    // per-line storage: write on push, clear popped slot on issue
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    live_q[g] <= '0;
                    br_q[g]   <= '0;
                    tk_q[g]   <= '0;
                    tgt_q[g]  <= '0;
                    base_q[g] <= '0;
                end else if (push && wr_ptr == PW'(g)) begin
                    live_q[g] <= push_live;
                    br_q[g]   <= push_br;
                    tk_q[g]   <= push_tk;
                    tgt_q[g]  <= push_tgt;
                    base_q[g] <= push_base;
                end else if (pop && rd_ptr == PW'(g)) begin
                    live_q[g] <= head_clr;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tpb_verify.sv
// Module tpb_verify
// Holds the instruction issued last cycle (the decode stage) together with
// the prediction that went with it, and compares it against the resolved
// outcome supplied by the core in that decode cycle.
// Assumes res_* are meaningful only while an instruction is in decode.
module tpb_verify #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_fire,
    input  logic [AW-1:0] issue_pc,
    input  logic          issue_br,
    input  logic          issue_tk,
    input  logic [AW-1:0] issue_tgt,
    input  logic          res_taken,
    input  logic [AW-1:0] res_target,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc
);
    import tpb_pkg::*;

    logic          dec_vld;
    logic [AW-1:0] dec_pc;
    logic          dec_br;
    logic          dec_tk;
    logic [AW-1:0] dec_tgt;
    verdict_e      verdict;

    // capture the issued instruction into the decode stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld <= 1'b0;
            dec_pc  <= '0;
            dec_br  <= 1'b0;
            dec_tk  <= 1'b0;
            dec_tgt <= '0;
        end else begin
            dec_vld <= issue_fire;
            dec_pc  <= issue_pc;
            dec_br  <= issue_br;
            dec_tk  <= issue_tk;
            dec_tgt <= issue_tgt;
        end
    end

    // classify the decode-stage prediction against the resolved outcome
    always_comb begin
        if (!dec_vld || !dec_br)                  verdict = VERD_NONE;
        else if (dec_tk != res_taken)             verdict = VERD_DIR_MISS;
        else if (dec_tk && (dec_tgt != res_target)) verdict = VERD_TGT_MISS;
        else                                      verdict = VERD_MATCH;
    end

    // corrected address for both program counters
    always_comb begin
        redirect_valid = (verdict == VERD_DIR_MISS) || (verdict == VERD_TGT_MISS);
        redirect_pc    = res_taken ? res_target : dec_pc + (AW'(1) << INSN_SHIFT);
    end
endmodule

// File: rtl/tgt_pred_buf.sv
// Module tgt_pred_buf (top)
// Per-slot prediction buffer running beside the fetch line queue. Accepts
// lines with per-slot hints, issues live slots in order with their
// prediction, checks the prediction in decode and redirects both PCs in
// the same cycle on a mismatch, flushing all buffered lines on the next edge.
// Assumes the core supplies res_* in the cycle after an issue handshake.
module tgt_pred_buf #(
    parameter int unsigned LINES = 3,
    parameter int unsigned SLOTS = 4,
    parameter int unsigned AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fill_valid,
    output logic                fill_ready,
    input  logic [AW-1:0]       fill_base_pc,
    input  logic [SLOTS-1:0]    fill_slot_vld,
    input  logic [SLOTS-1:0]    fill_is_br,
    input  logic [SLOTS-1:0]    fill_pred_tk,
    input  logic [SLOTS*AW-1:0] fill_pred_tgt,
    output logic                buf_empty,
    output logic                buf_full,
    output logic                issue_valid,
    input  logic                issue_ready,
    output logic [AW-1:0]       issue_pc,
    output logic                issue_is_br,
    output logic                issue_pred_tk,
    output logic [AW-1:0]       issue_pred_tgt,
    input  logic                res_taken,
    input  logic [AW-1:0]       res_target,
    output logic                redirect_valid,
    output logic [AW-1:0]       redirect_pc
);
    logic [SLOTS-1:0] live;
    logic             push;
    logic             issue_fire;
    logic [AW-1:0]    head_pc;
    logic             head_br;
    logic             head_tk;
    logic [AW-1:0]    head_tgt;

    tpb_fill_mask #(.SLOTS(SLOTS)) u_mask (
        .slot_vld (fill_slot_vld),
        .is_br    (fill_is_br),
        .pred_tk  (fill_pred_tk),
        .live     (live)
    );

    // accept a line only with room, no redirect, and at least one live slot
    always_comb begin
        fill_ready = !buf_full;
        push       = fill_valid && fill_ready && !redirect_valid && (live != '0);
    end

    tpb_line_store #(.LINES(LINES), .SLOTS(SLOTS), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_base (fill_base_pc),
        .push_live (live),
        .push_br   (fill_is_br),
        .push_tk   (fill_pred_tk),
        .push_tgt  (fill_pred_tgt),
        .pop       (issue_fire),
        .flush     (redirect_valid),
        .empty     (buf_empty),
        .full      (buf_full),
        .head_pc   (head_pc),
        .head_br   (head_br),
        .head_tk   (head_tk),
        .head_tgt  (head_tgt)
    );

    // present the head slot with a cleaned-up prediction
    always_comb begin
        issue_valid    = !buf_empty && !redirect_valid;
        issue_fire     = issue_valid && issue_ready;
        issue_pc       = head_pc;
        issue_is_br    = head_br;
        issue_pred_tk  = head_br && head_tk;
        issue_pred_tgt = (head_br && head_tk) ? head_tgt : '0;
    end

    tpb_verify #(.AW(AW)) u_verify (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_fire     (issue_fire),
        .issue_pc       (issue_pc),
        .issue_br       (issue_is_br),
        .issue_tk       (issue_pred_tk),
        .issue_tgt      (issue_pred_tgt),
        .res_taken      (res_taken),
        .res_target     (res_target),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );
endmodule

// File: rtl/tpb_checker.sv
// Module tpb_checker
// Temporal properties of tgt_pred_buf, observed at its ports.
module tpb_checker #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fill_ready,
    input logic          buf_empty,
    input logic          buf_full,
    input logic          issue_valid,
    input logic          issue_ready,
    input logic          issue_is_br,
    input logic          issue_pred_tk,
    input logic [AW-1:0] issue_pred_tgt,
    input logic          redirect_valid
);
    a_r1_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_empty && buf_full));

    a_r3_no_room_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !fill_ready);

    a_r5_plain_insn_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_is_br) |-> (!issue_pred_tk && issue_pred_tgt == '0));

    a_r6_redirect_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(issue_valid && issue_ready));

    a_r8_redirect_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(issue_is_br));

    a_r9_no_issue_in_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !issue_valid);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (buf_empty && !redirect_valid));
endmodule

bind tgt_pred_buf tpb_checker #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fill_ready     (fill_ready),
    .buf_empty      (buf_empty),
    .buf_full       (buf_full),
    .issue_valid    (issue_valid),
    .issue_ready    (issue_ready),
    .issue_is_br    (issue_is_br),
    .issue_pred_tk  (issue_pred_tk),
    .issue_pred_tgt (issue_pred_tgt),
    .redirect_valid (redirect_valid)
);

// File: tb/sim_tgt_pred_buf.sv
// Directed bench for tgt_pred_buf: one task per scenario.
module sim_tgt_pred_buf;
    localparam int unsigned LINES = 3;
    localparam int unsigned SLOTS = 4;
    localparam int unsigned AW    = 32;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                fill_valid;
    logic                fill_ready;
    logic [AW-1:0]       fill_base_pc;
    logic [SLOTS-1:0]    fill_slot_vld;
    logic [SLOTS-1:0]    fill_is_br;
    logic [SLOTS-1:0]    fill_pred_tk;
    logic [SLOTS*AW-1:0] fill_pred_tgt;
    logic                buf_empty;
    logic                buf_full;
    logic                issue_valid;
    logic                issue_ready;
    logic [AW-1:0]       issue_pc;
    logic                issue_is_br;
    logic                issue_pred_tk;
    logic [AW-1:0]       issue_pred_tgt;
    logic                res_taken;
    logic [AW-1:0]       res_target;
    logic                redirect_valid;
    logic [AW-1:0]       redirect_pc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tgt_pred_buf #(.LINES(LINES), .SLOTS(SLOTS), .AW(AW)) u0 (.*);

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // offer one line for one cycle; ends just after the following negedge
    task automatic push_line(input logic [AW-1:0] base, input logic [3:0] vld,
                             input logic [3:0] br, input logic [3:0] tk,
                             input logic [SLOTS*AW-1:0] tgt);
        fill_valid    = 1'b1;
        fill_base_pc  = base;
        fill_slot_vld = vld;
        fill_is_br    = br;
        fill_pred_tk  = tk;
        fill_pred_tgt = tgt;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
    endtask

    // issue one instruction, then supply its outcome in decode and check redirect
    task automatic take(input string req, input logic [AW-1:0] pc, input logic br,
                        input logic tk, input logic [AW-1:0] tgt,
                        input logic rtk, input logic [AW-1:0] rtgt,
                        input logic exp_rd, input logic [AW-1:0] exp_rpc);
        chk({req, " issue_valid"}, AW'(issue_valid), 1);
        chk({req, " issue_pc"}, issue_pc, pc);
        chk({req, " issue_is_br"}, AW'(issue_is_br), AW'(br));
        chk({req, " issue_pred_tk"}, AW'(issue_pred_tk), AW'(tk));
        chk({req, " issue_pred_tgt"}, issue_pred_tgt, tgt);
        issue_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue_ready = 1'b0;
        res_taken   = rtk;
        res_target  = rtgt;
        #1;
        chk({req, " redirect_valid"}, AW'(redirect_valid), AW'(exp_rd));
        if (exp_rd) chk({req, " redirect_pc"}, redirect_pc, exp_rpc);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 buf_empty", AW'(buf_empty), 1);
        chk("R1 buf_full", AW'(buf_full), 0);
        chk("R1 fill_ready", AW'(fill_ready), 1);
        chk("R1 issue_valid", AW'(issue_valid), 0);
        chk("R1 redirect_valid", AW'(redirect_valid), 0);
    endtask

    // R2 order, R5 plain prediction, R8 no redirect on non-branch
    task automatic t_order();
        push_line(32'h100, 4'hF, 4'h0, 4'h0, '0);
        push_line(32'h200, 4'hF, 4'h0, 4'h0, '0);
        for (int i = 0; i < 4; i++)
            take("R2 R8 line A", 32'h100 + 32'(4*i), 0, 0, 0, 1, 32'hDEAD0, 0, 0);
        for (int i = 0; i < 4; i++)
            take("R2 R5 line B", 32'h200 + 32'(4*i), 0, 0, 0, 1, 32'hBEEF0, 0, 0);
        chk("R2 drained", AW'(buf_empty), 1);
    endtask

    // R3 full flag, dropped fill while full
    task automatic t_full();
        push_line(32'h1000, 4'hF, 4'h0, 4'h0, '0);
        push_line(32'h1100, 4'hF, 4'h0, 4'h0, '0);
        chk("R3 not full at 2", AW'(buf_full), 0);
        push_line(32'h1200, 4'hF, 4'h0, 4'h0, '0);
        chk("R3 buf_full", AW'(buf_full), 1);
        chk("R3 fill_ready", AW'(fill_ready), 0);
        push_line(32'h9000, 4'hF, 4'h0, 4'h0, '0);
        for (int l = 0; l < 3; l++)
            for (int s = 0; s < 4; s++)
                take("R3 drain", 32'h1000 + 32'(l*'h100) + 32'(4*s), 0, 0, 0, 0, 0, 0, 0);
        chk("R3 full-time fill dropped", AW'(buf_empty), 1);
        chk("R3 no extra issue", AW'(issue_valid), 0);
    endtask

    // R4 masking, R7 matching taken prediction, R5 not-taken target zero
    task automatic t_mask();
        // slot1 branch predicted taken to 0x800; slots 2,3 shadowed
        push_line(32'h400, 4'hF, 4'b0110, 4'b0110, {32'h1, 32'h2, 32'h800, 32'h0});
        // slot0 absent; slot1 branch predicted not taken with junk target
        push_line(32'h500, 4'b1110, 4'b0010, 4'b0000, {32'h0, 32'h0, 32'h777, 32'h0});
        take("R4 slot0", 32'h400, 0, 0, 0, 0, 0, 0, 0);
        take("R7 taken match", 32'h404, 1, 1, 32'h800, 1, 32'h800, 0, 0);
        take("R4 skip absent", 32'h504, 1, 0, 0, 0, 0, 0, 0);
        take("R4 slot2", 32'h508, 0, 0, 0, 0, 0, 0, 0);
        take("R4 slot3", 32'h50C, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 shadowed slots never issued", AW'(buf_empty), 1);
    endtask

    // R6 direction miss, R9 flush of queued lines
    task automatic t_dir_miss();
        push_line(32'h2000, 4'hF, 4'b0001, 4'b0000, '0);
        push_line(32'h2100, 4'hF, 4'h0, 4'h0, '0);
        take("R6 nt->t", 32'h2000, 1, 0, 0, 1, 32'h2400, 1, 32'h2400);
        chk("R9 no issue during redirect", AW'(issue_valid), 0);
        step();
        chk("R9 flushed empty", AW'(buf_empty), 1);
        chk("R9 redirect cleared", AW'(redirect_valid), 0);
        push_line(32'h2800, 4'hF, 4'b0100, 4'b0100, {32'h0, 32'h2C00, 32'h0, 32'h0});
        take("R4 pre", 32'h2800, 0, 0, 0, 0, 0, 0, 0);
        take("R4 pre", 32'h2804, 0, 0, 0, 0, 0, 0, 0);
        take("R6 t->nt", 32'h2808, 1, 1, 32'h2C00, 0, 32'h5555, 1, 32'h280C);
        step();
        chk("R9 empty after t->nt", AW'(buf_empty), 1);
    endtask

    // R7 target miss with a fill offered in the redirect cycle (R9)
    task automatic t_tgt_miss_fill();
        push_line(32'h6000, 4'hF, 4'b0001, 4'b0001, {32'h0, 32'h0, 32'h0, 32'h6800});
        push_line(32'h6100, 4'hF, 4'h0, 4'h0, '0);
        // slot0 is a taken branch: slots 1..3 of 0x6000 are shadowed
        take("R7 target miss", 32'h6000, 1, 1, 32'h6800, 1, 32'h6900, 1, 32'h6900);
        fill_valid    = 1'b1;
        fill_base_pc  = 32'h7000;
        fill_slot_vld = 4'hF;
        fill_is_br    = 4'h0;
        fill_pred_tk  = 4'h0;
        fill_pred_tgt = '0;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        chk("R9 fill in redirect cycle dropped", AW'(buf_empty), 1);
        chk("R9 nothing issued after flush", AW'(issue_valid), 0);
    endtask

    initial begin
        rst_n = 1'b0; fill_valid = 1'b0; fill_base_pc = '0; fill_slot_vld = '0;
        fill_is_br = '0; fill_pred_tk = '0; fill_pred_tgt = '0;
        issue_ready = 1'b0; res_taken = 1'b0; res_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_order();
        t_full();
        t_mask();
        t_dir_miss();
        t_tgt_miss_fill();
        finish_run();
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end
endmodule